// File: doc/BRIEF.md
# Multichannel servo pulse generator

This block drives a bank of hobby-servo style control outputs. All channels share one fixed frame (20 ms at the default 50 MHz clock, counted directly in clocks). At the start of every frame each enabled output goes high. It stays high for a width that software sets per channel, measured in resolution steps. A step-length prescaler sets the step, and software may rewrite it at any time. The default range of the prescaler covers steps from 10 us (500 clocks) to 100 us (5,000 clocks) and beyond. Whatever width and step are programmed, the resulting high time is held inside a fixed 0.5 ms to 2.5 ms window.

Software writes a small word-addressed register space: one width register per channel, one prescaler terminal-count register and one enable bit. Every write lands in a pending copy and is moved into the working copy only on the edge that begins a new frame. A running frame therefore never changes shape in the middle. A one-cycle frame-start strobe lets software pace its updates. The channel count is a parameter: five by default, and thirteen or more is a matter of setting it.

Top module: `servo_pwm_bank`

## Requirements
- R1: The frame lasts exactly FRAME_CLKS clocks. `frame_start_o` is high for exactly the first cycle of each frame and low in all other cycles.
- R2: In every frame, each enabled output is high from the frame's first cycle for one contiguous run of H cycles and then low until the frame ends. All enabled outputs rise in the same cycle.
- R3: With width register W and prescaler terminal count T (the step counter runs 0..T, so one step is T+1 clocks), H = W*(T+1) when that value lies inside the clamp window.
- R4: H is saturated to the range [MIN_CLKS, MAX_CLKS]. A width of 0 gives MIN_CLKS, and a width whose product exceeds MAX_CLKS gives MAX_CLKS.
- R5: A new prescaler value changes the step length only from the next frame start. The step count restarts at every frame start.
- R6: Bit 0 of the enable register is the enable. While the working enable is 0, every output stays low for the whole frame. A change of the enable takes effect at a frame start.
- R7: A synchronous active-high `rst` drives every output low, clears the counters, clears the enable, loads RST_WIDTH into every width and RST_TC into the prescaler, and starts a frame in the first cycle after reset.
- R8: A register write changes the current frame in no way. A write made in the last cycle of a frame is captured on the same edge that begins the next frame, so it takes effect one frame later.
- R9: The address map is as follows. Addresses 0..NCH-1 are the channel widths (low WW bits of `wr_data`). Address NCH is the prescaler terminal count. Address NCH+1 is the enable. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW = clog2(NCH+2) | Register word address |
| wr_data | input | PW | Write data |
| pwm_o | output | NCH | Servo pulse outputs, bit i is channel i |
| frame_start_o | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
A register write and the frame-start transfer can fall on the same clock edge. The write lands in the pending copy while the transfer moves the old pending value into the working copy. The bench provokes this by issuing a width write in the last cycle of a frame. It then judges the following frame, which must still carry the previous width, and the frame after it, which must carry the new one. The scoreboard predicts every frame from a model that updates only after each write's edge. Mid-frame writes for widths, prescaler, enable and an unmapped address are judged the same way.

// File: rtl/servo_pkg.sv
package servo_pkg;

  // Output level for frame position k with `ticks` completed steps.
  // Before MIN the pulse is forced high; after MAX it is forced low.
  function automatic logic pulse_on(input int unsigned k,
                                    input int unsigned ticks,
                                    input int unsigned width,
                                    input int unsigned min_c,
                                    input int unsigned max_c);
    return (k < min_c) || ((ticks < width) && (k < max_c));
  endfunction

endpackage

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
  parameter int unsigned FRAME_CLKS = 1_000_000,
  parameter int unsigned PW         = 13,
  parameter int unsigned TW         = 9,
  localparam int unsigned FW        = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] tc_act,
  output logic [FW-1:0] frame_cnt,
  output logic [TW-1:0] ticks,
  output logic          frame_wrap
);

  localparam logic [FW-1:0] LAST_K = FW'(FRAME_CLKS - 1);

  logic [PW-1:0] step_cnt;
  logic          step_tick;

  assign frame_wrap = (frame_cnt == LAST_K);
  assign step_tick  = (step_cnt == tc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      step_cnt  <= '0;
      ticks     <= '0;
    end else if (frame_wrap) begin
      frame_cnt <= '0;
      step_cnt  <= '0;
      ticks     <= '0;
    end else begin
      frame_cnt <= frame_cnt + 1'b1;
      if (step_tick) begin
        step_cnt <= '0;
        if (ticks != '1) ticks <= ticks + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/servo_cfg_regs.sv
module servo_cfg_regs #(
  parameter int unsigned NCH       = 5,
  parameter int unsigned AW        = 3,
  parameter int unsigned WW        = 8,
  parameter int unsigned PW        = 13,
  parameter int unsigned RST_TC    = 4999,
  parameter int unsigned RST_WIDTH = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [PW-1:0]          wr_data,
  input  logic                   load,
  output logic [NCH-1:0][WW-1:0] w_act,
  output logic [PW-1:0]          tc_act,
  output logic                   en_act
);

  localparam logic [AW-1:0] TC_ADDR = AW'(NCH);
  localparam logic [AW-1:0] EN_ADDR = AW'(NCH + 1);

  logic [NCH-1:0][WW-1:0] w_pend;
  logic [PW-1:0]          tc_pend;
  logic                   en_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        w_pend[i] <= WW'(RST_WIDTH);
        w_act[i]  <= WW'(RST_WIDTH);
      end
      tc_pend <= PW'(RST_TC);
      tc_act  <= PW'(RST_TC);
      en_pend <= 1'b0;
      en_act  <= 1'b0;
    end else begin
      if (wr_en) begin
        for (int i = 0; i < NCH; i++)
          if (wr_addr == AW'(i)) w_pend[i] <= wr_data[WW-1:0];
        if (wr_addr == TC_ADDR) tc_pend <= wr_data;
        if (wr_addr == EN_ADDR) en_pend <= wr_data[0];
      end
      if (load) begin
        w_act  <= w_pend;
        tc_act <= tc_pend;
        en_act <= en_pend;
      end
    end
  end

endmodule

// File: rtl/servo_pulse_chan.sv
module servo_pulse_chan
  import servo_pkg::*;
#(
  parameter int unsigned FW       = 20,
  parameter int unsigned TW       = 9,
  parameter int unsigned WW       = 8,
  parameter int unsigned MIN_CLKS = 25_000,
  parameter int unsigned MAX_CLKS = 125_000
) (
  input  logic [FW-1:0] frame_cnt,
  input  logic [TW-1:0] ticks,
  input  logic [WW-1:0] width,
  input  logic          en,
  output logic          pwm
);

  assign pwm = en & pulse_on(32'(frame_cnt), 32'(ticks), 32'(width),
                             MIN_CLKS, MAX_CLKS);

endmodule

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int unsigned NCH        = 5,
  parameter int unsigned FRAME_CLKS = 1_000_000,
  parameter int unsigned MIN_CLKS   = 25_000,
  parameter int unsigned MAX_CLKS   = 125_000,
  parameter int unsigned WW         = 8,
  parameter int unsigned PW         = 13,
  parameter int unsigned RST_TC     = 4999,
  parameter int unsigned RST_WIDTH  = 15,
  localparam int unsigned AW        = $clog2(NCH + 2),
  localparam int unsigned FW        = $clog2(FRAME_CLKS),
  localparam int unsigned TW        = WW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [PW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o,
  output logic           frame_start_o
);

  logic [NCH-1:0][WW-1:0] w_act;
  logic [PW-1:0]          tc_act;
  logic                   en_act;
  logic [FW-1:0]          frame_cnt;
  logic [TW-1:0]          ticks;
  logic                   frame_wrap;   // last cycle of a frame; shadow load edge

  servo_cfg_regs #(
    .NCH(NCH), .AW(AW), .WW(WW), .PW(PW),
    .RST_TC(RST_TC), .RST_WIDTH(RST_WIDTH)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(frame_wrap),
    .w_act(w_act), .tc_act(tc_act), .en_act(en_act)
  );

  servo_frame_timer #(
    .FRAME_CLKS(FRAME_CLKS), .PW(PW), .TW(TW)
  ) u_timer (
    .clk(clk), .rst(rst), .tc_act(tc_act),
    .frame_cnt(frame_cnt), .ticks(ticks), .frame_wrap(frame_wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    servo_pulse_chan #(
      .FW(FW), .TW(TW), .WW(WW),
      .MIN_CLKS(MIN_CLKS), .MAX_CLKS(MAX_CLKS)
    ) u_chan (
      .frame_cnt(frame_cnt), .ticks(ticks), .width(w_act[g]),
      .en(en_act), .pwm(pwm_o[g])
    );
  end

  assign frame_start_o = (frame_cnt == '0);

endmodule

// File: rtl/servo_pwm_bank_chk.sv
module servo_pwm_bank_chk #(
  parameter int unsigned NCH        = 5,
  parameter int unsigned FRAME_CLKS = 1_000_000,
  parameter int unsigned MIN_CLKS   = 25_000,
  parameter int unsigned MAX_CLKS   = 125_000,
  localparam int unsigned GW        = $clog2(FRAME_CLKS) + 2
) (
  input logic           clk,
  input logic           rst,
  input logic           frame_wrap,
  input logic           frame_start_o,
  input logic [NCH-1:0] pwm_o
);

  logic [GW-1:0] gap;      // cycles since the last strobe
  logic          seen;     // a full frame has been observed
  logic          rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (frame_start_o) begin
      gap  <= GW'(1);
      seen <= (gap != '0);
    end else begin
      gap <= gap + 1'b1;
    end
    if (rst_d) begin
      p_reset_low_r7: assert (pwm_o == '0)
        else $error("outputs not low after reset edge");
    end
  end

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);

  p_wrap_then_start_r1: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> frame_start_o);

  p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && seen) |-> (gap == GW'(FRAME_CLKS)));

  p_rise_at_start_r2: assert property (@(posedge clk) disable iff (rst)
    ((pwm_o & ~$past(pwm_o)) != '0) |-> frame_start_o);

  p_low_past_max_r4: assert property (@(posedge clk) disable iff (rst)
    (!frame_start_o && gap >= GW'(MAX_CLKS)) |-> (pwm_o == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_fall
    p_fall_window_r4: assert property (@(posedge clk) disable iff (rst)
      ($fell(pwm_o[g]) && !frame_start_o) |->
        (gap >= GW'(MIN_CLKS) && gap <= GW'(MAX_CLKS)));
  end

endmodule

bind servo_pwm_bank servo_pwm_bank_chk #(
  .NCH(NCH), .FRAME_CLKS(FRAME_CLKS),
  .MIN_CLKS(MIN_CLKS), .MAX_CLKS(MAX_CLKS)
) u_chk (
  .clk(clk), .rst(rst), .frame_wrap(frame_wrap),
  .frame_start_o(frame_start_o), .pwm_o(pwm_o)
);

// File: tb/servo_pwm_bank_tb.sv
module servo_pwm_bank_tb;

  localparam int NCH   = 3;
  localparam int FRAME = 400;
  localparam int MINC  = 40;
  localparam int MAXC  = 200;
  localparam int WW    = 8;
  localparam int PW    = 13;
  localparam int AW    = $clog2(NCH + 2);

  typedef logic [NCH-1:0][15:0] hv_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [PW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_o;
  logic           frame_start_o;

  always #5 clk = ~clk;

  servo_pwm_bank #(
    .NCH(NCH), .FRAME_CLKS(FRAME), .MIN_CLKS(MINC), .MAX_CLKS(MAXC),
    .WW(WW), .PW(PW), .RST_TC(9), .RST_WIDTH(15)
  ) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .frame_start_o(frame_start_o)
  );

  int checks = 0;
  int fails  = 0;

  // bench register model (updated after each write's edge)
  int    m_w [NCH];
  int    m_tc = 9;
  bit    m_en = 1'b0;
  string cur_tag = "R7";

  hv_t   exp_q[$];
  string tag_q[$];

  function automatic int hold_of(int w, int tc, bit en);
    int raw;
    if (!en) return 0;
    raw = w * (tc + 1);
    if (raw < MINC) return MINC;
    if (raw > MAXC) return MAXC;
    return raw;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  int  k = 0;
  bit  meas_valid = 0;
  int  cnt [NCH];
  bit  low_seen [NCH];
  bit  broken [NCH];

  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete();
      tag_q.delete();
      exp_q.push_back('0);
      tag_q.push_back("R7");
      meas_valid = 0;
      k = 0;
    end else begin
      if (frame_start_o) begin
        if (meas_valid && exp_q.size() > 0) begin
          hv_t   e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(k == FRAME - 1, "R1 frame length", k + 1, FRAME);
          for (int c = 0; c < NCH; c++) begin
            check(cnt[c] == int'(e[c]), t, cnt[c], int'(e[c]));
            check(!broken[c], "R2 single contiguous pulse", int'(broken[c]), 0);
          end
        end
        meas_valid = 1;
        k = 0;
        for (int c = 0; c < NCH; c++) begin
          cnt[c] = 0; low_seen[c] = 0; broken[c] = 0;
        end
      end else begin
        k++;
      end
      if (meas_valid) begin
        for (int c = 0; c < NCH; c++) begin
          if (pwm_o[c]) begin
            if (low_seen[c]) broken[c] = 1;
            cnt[c]++;
          end else begin
            low_seen[c] = 1;
          end
        end
        if (k == FRAME - 1) begin
          hv_t e;
          for (int c = 0; c < NCH; c++) e[c] = 16'(hold_of(m_w[c], m_tc, m_en));
          exp_q.push_back(e);
          tag_q.push_back(cur_tag);
        end
      end
    end
  end

  // driver: called at a negedge, returns at the next negedge
  task automatic wr(int addr, int data);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = PW'(data);
    @(posedge clk);
    #1;
    if (addr < NCH) m_w[addr] = data & ((1 << WW) - 1);
    else if (addr == NCH) m_tc = data;
    else if (addr == NCH + 1) m_en = data[0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!frame_start_o) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) m_w[c] = 15;
    repeat (4) @(negedge clk);
    check(pwm_o == '0, "R7 outputs low in reset", int'(pwm_o), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(frame_start_o == 1'b1, "R7 strobe after reset", int'(frame_start_o), 1);
    check(pwm_o == '0, "R7 enable clear after reset", int'(pwm_o), 0);

    // frame A: turn on, default widths (R6, R7)
    cur_tag = "R6 R7 enable and default width";
    repeat (50) @(negedge clk);
    wr(NCH + 1, 1);

    // frame B: mid-frame width writes must not touch B (R8), apply in C (R3)
    wait_start();
    cur_tag = "R3 R8 width steps";
    repeat (100) @(negedge clk);
    wr(0, 5); wr(1, 12); wr(2, 20);

    // frame C: clamp cases (R4)
    wait_start();
    cur_tag = "R4 clamp";
    repeat (60) @(negedge clk);
    wr(0, 2); wr(1, 30); wr(2, 0);

    // frame D: prescaler change (R5)
    wait_start();
    cur_tag = "R5 prescaler change";
    repeat (250) @(negedge clk);
    wr(NCH, 4); wr(0, 10); wr(1, 30); wr(2, 3);

    // frame E: unmapped address (R9)
    wait_start();
    cur_tag = "R9 unmapped write";
    repeat (30) @(negedge clk);
    wr(7, 1);

    // frame F: write on the load edge (R8)
    wait_start();
    cur_tag = "R8 write on frame edge";
    repeat (FRAME - 1) @(negedge clk);
    wr(0, 16);

    // frame G keeps old width, H carries 16*5=80
    wait_start();
    cur_tag = "R8 after edge write";
    wait_start();
    cur_tag = "R6 disable";
    repeat (10) @(negedge clk);
    wr(NCH + 1, 0);
    wait_start();
    wait_start();
    wait_start();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule